// File: doc/BRIEF.md
# Right-to-Left Modular Exponentiation Sequencer

This block drives an external Montgomery multiplier to compute C = M^E mod N. Every product is taken by the multiplier. The block itself does no arithmetic. It decides which operations run and in what order. For each operation it names the two source memories and the destination memory, then waits until the multiplier reports completion.

Five word-addressed memories are identified by slot numbers:

| Slot | Role |
|---|---|
| 0 | Modulus N |
| 1 | Exponent E |
| 2 | Base M (input) |
| 3 | Working memory |
| 4 | R² mod N (input) |

The job runs in three phases:

- **Entry.** The base is brought into the Montgomery domain, and R mod N is derived from R² mod N.
- **Scan.** The exponent is read from bit 0 upward.
- **Exit.** A final multiply by the constant one leaves the domain.

Slots 2, 3 and 4 change roles during a job. The block renames them through pointers and never copies data between them. The exponent memory is read on the falling clock edge, so a bit whose address is set on one rising edge can be used at the next rising edge.

A second mode performs a single product of slot 2 by slot 4 and no scan. While a job runs, a host read of the exponent slot is refused.

Top module: `rl_modexp_seq`

## Requirements
- R1: After reset `busy`, `done` and `mul_start` are 0.
- R2: An exponentiation job (`mode_mul`=0) begins with two commands, in this order:
  - MM(slot 2, slot 4) → slot 3.
  - MM(slot 4, one) → slot 2, where one means `mul_b_one`=1.
  - After these, the accumulator is in slot 2, the square in slot 3 and the spare in slot 4.
- R3: Exponent bits are processed for i = 0 up to `exp_bits`−1.
  - When bit i is 1, the block issues MM(acc, sq) → spare, and the accumulator and spare roles then swap.
  - When i is not the last bit, the block issues MM(sq, sq) → spare, and the square and spare roles then swap.
- R4: The last command is MM(acc, one) → spare. `done` pulses for one cycle in the cycle after that command's `mul_done`. In the same cycle `busy` falls and `res_slot` names the destination of that command, which then holds M^E mod N.
- R5: No command writes slot 0 or slot 1, and no command writes one of its own sources.
- R6: Bit i of the exponent is bit (i mod 32) of word (i div 32), read at `exp_addr`. The word is returned in `exp_rdata` on the falling edge after the address is set.
- R7: `mul_len` equals `op_len` as sampled at start, and stays constant while `busy` is high.
- R8: `mul_start` is a one-cycle pulse. It is high only while `busy` is high, and at most one multiply is outstanding at a time.
- R9: With `mode_mul`=1 the job is one command, MM(slot 2, slot 4) → slot 3, followed by `done` with `res_slot`=3.
- R10: `host_rd_grant` equals `host_rd_req`, except that it is 0 while `busy` is high and `host_rd_slot` is 1.
- R11: A start pulse while `busy` is high has no effect on the command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (ignored while busy) |
| mode_mul | input | 1 | 1: single product, 0: exponentiation |
| op_len | input | LEN_W | Operand length in bits |
| exp_bits | input | LEN_W | Exponent length in bits (at least 1) |
| exp_addr | output | AW | Exponent word address |
| exp_rdata | input | WORD | Exponent word read on the falling edge |
| mul_start | output | 1 | Command pulse to the multiplier |
| mul_a | output | 3 | Source slot A |
| mul_b | output | 3 | Source slot B (unused when `mul_b_one` is 1) |
| mul_b_one | output | 1 | Use the constant one as operand B |
| mul_dst | output | 3 | Destination slot |
| mul_len | output | LEN_W | Operand length for the multiplier |
| mul_done | input | 1 | Multiplier completion pulse |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job complete pulse |
| res_slot | output | 3 | Slot holding the result |
| host_rd_req | input | 1 | Host read request |
| host_rd_slot | input | 3 | Slot the host wants to read |
| host_rd_grant | output | 1 | Host read allowed |

## Verification
Exponents are chosen to separate the different paths through the scan:

- **Mixed pattern (1011).** Exercises both the multiply branch and the skip branch.
- **Single set bit of length one.** Checks that no square follows the last bit.
- **All-zero exponent.** Must still return 1.
- **70-bit exponent.** Crosses two word boundaries and shows whether the word address and bit select are correct.

The single-product mode is run to show that it skips both the entry and the scan. A start pulse during a long job, and an operand length changed after start, show whether the inputs latched at start are protected. A small multiplier model computes real Montgomery products, so a wrong slot choice shows up as a wrong number.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
  localparam int SLOT_W = 3;
  typedef logic [SLOT_W-1:0] slot_t;

  localparam slot_t SLOT_N    = 3'd0;
  localparam slot_t SLOT_E    = 3'd1;
  localparam slot_t SLOT_BASE = 3'd2;
  localparam slot_t SLOT_WK   = 3'd3;
  localparam slot_t SLOT_R2   = 3'd4;

  typedef enum logic [2:0] {
    OP_TOMONT, OP_RINIT, OP_MULACC, OP_SQR, OP_EXIT, OP_SINGLE
  } op_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_DECIDE
  } st_t;
endpackage

// File: rtl/modexp_bitscan.sv
module modexp_bitscan #(
  parameter int WORD  = 32,
  parameter int LEN_W = 12,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [LEN_W-1:0] nbits,
  input  logic [WORD-1:0]  rdata,
  output logic [AW-1:0]    addr,
  output logic             cur_bit,
  output logic             is_last
);
  localparam int WLG = $clog2(WORD);

  logic [LEN_W-1:0] idx_q, idx_d, last_q, last_d;

  always_comb begin
    idx_d  = idx_q;
    last_d = last_q;
    if (load) begin
      idx_d  = '0;
      last_d = nbits - 1'b1;
    end else if (adv) begin
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  assign addr    = idx_q[WLG +: AW];
  assign cur_bit = rdata[idx_q[WLG-1:0]];
  assign is_last = (idx_q == last_q);
endmodule

// File: rtl/modexp_roles.sv
module modexp_roles
  import modexp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  init,
  input  logic  swap_acc,
  input  logic  swap_sq,
  output slot_t acc_p,
  output slot_t sq_p,
  output slot_t spr_p
);
  slot_t acc_d, sq_d, spr_d;

  always_comb begin
    acc_d = acc_p;
    sq_d  = sq_p;
    spr_d = spr_p;
    if (init) begin
      acc_d = SLOT_BASE;
      sq_d  = SLOT_WK;
      spr_d = SLOT_R2;
    end else if (swap_acc) begin
      acc_d = spr_p;
      spr_d = acc_p;
    end else if (swap_sq) begin
      sq_d  = spr_p;
      spr_d = sq_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_p <= SLOT_BASE;
      sq_p  <= SLOT_WK;
      spr_p <= SLOT_R2;
    end else begin
      acc_p <= acc_d;
      sq_p  <= sq_d;
      spr_p <= spr_d;
    end
  end
endmodule

// File: rtl/modexp_rdguard.sv
module modexp_rdguard
  import modexp_pkg::*;
(
  input  logic  busy,
  input  logic  req,
  input  slot_t slot,
  output logic  grant
);
  assign grant = req && !(busy && (slot == SLOT_E));
endmodule

// File: rtl/rl_modexp_seq.sv
module rl_modexp_seq
  import modexp_pkg::*;
#(
  parameter int WORD     = 32,
  parameter int MAX_BITS = 2048,
  localparam int LEN_W   = $clog2(MAX_BITS + 1),
  localparam int AW      = $clog2(MAX_BITS / WORD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_mul,
  input  logic [LEN_W-1:0] op_len,
  input  logic [LEN_W-1:0] exp_bits,
  output logic [AW-1:0]    exp_addr,
  input  logic [WORD-1:0]  exp_rdata,
  output logic             mul_start,
  output logic [2:0]       mul_a,
  output logic [2:0]       mul_b,
  output logic             mul_b_one,
  output logic [2:0]       mul_dst,
  output logic [LEN_W-1:0] mul_len,
  input  logic             mul_done,
  output logic             busy,
  output logic             done,
  output logic [2:0]       res_slot,
  input  logic             host_rd_req,
  input  logic [2:0]       host_rd_slot,
  output logic             host_rd_grant
);
  st_t   st_q, st_d;
  op_t   op_q, op_d;
  logic  busy_d, done_d;
  logic  [LEN_W-1:0] len_q, len_d;
  slot_t res_q, res_d;
  logic  scan_load, scan_adv, role_init, swap_acc, swap_sq;
  logic  cur_bit, is_last;
  slot_t acc_p, sq_p, spr_p;

  modexp_bitscan #(.WORD(WORD), .LEN_W(LEN_W), .AW(AW)) u_scan (
    .clk(clk), .rst_n(rst_n), .load(scan_load), .adv(scan_adv),
    .nbits(exp_bits), .rdata(exp_rdata), .addr(exp_addr),
    .cur_bit(cur_bit), .is_last(is_last)
  );

  modexp_roles u_roles (
    .clk(clk), .rst_n(rst_n), .init(role_init), .swap_acc(swap_acc),
    .swap_sq(swap_sq), .acc_p(acc_p), .sq_p(sq_p), .spr_p(spr_p)
  );

  modexp_rdguard u_guard (
    .busy(busy), .req(host_rd_req), .slot(host_rd_slot), .grant(host_rd_grant)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    busy_d    = busy;
    done_d    = 1'b0;
    len_d     = len_q;
    res_d     = res_q;
    scan_load = 1'b0;
    scan_adv  = 1'b0;
    role_init = 1'b0;
    swap_acc  = 1'b0;
    swap_sq   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        busy_d    = 1'b1;
        len_d     = op_len;
        scan_load = 1'b1;
        role_init = 1'b1;
        op_d      = mode_mul ? OP_SINGLE : OP_TOMONT;
        st_d      = ST_ISSUE;
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: if (mul_done) begin
        unique case (op_q)
          OP_TOMONT: begin
            op_d = OP_RINIT;
            st_d = ST_ISSUE;
          end
          OP_RINIT: st_d = ST_DECIDE;
          OP_MULACC: begin
            swap_acc = 1'b1;
            op_d     = is_last ? OP_EXIT : OP_SQR;
            st_d     = ST_ISSUE;
          end
          OP_SQR: begin
            swap_sq  = 1'b1;
            scan_adv = 1'b1;
            st_d     = ST_DECIDE;
          end
          default: begin  // OP_EXIT, OP_SINGLE finish the job
            res_d  = (op_q == OP_SINGLE) ? SLOT_WK : spr_p;
            busy_d = 1'b0;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        endcase
      end
      ST_DECIDE: begin
        st_d = ST_ISSUE;
        if (cur_bit)      op_d = OP_MULACC;
        else if (is_last) op_d = OP_EXIT;
        else              op_d = OP_SQR;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_TOMONT;
      busy  <= 1'b0;
      done  <= 1'b0;
      len_q <= '0;
      res_q <= SLOT_WK;
    end else begin
      st_q  <= st_d;
      op_q  <= op_d;
      busy  <= busy_d;
      done  <= done_d;
      len_q <= len_d;
      res_q <= res_d;
    end
  end

  // command decode
  always_comb begin
    mul_b_one = 1'b0;
    mul_a     = SLOT_BASE;
    mul_b     = SLOT_R2;
    mul_dst   = SLOT_WK;
    unique case (op_q)
      OP_RINIT: begin
        mul_a = SLOT_R2; mul_b = SLOT_R2; mul_b_one = 1'b1; mul_dst = SLOT_BASE;
      end
      OP_MULACC: begin
        mul_a = acc_p; mul_b = sq_p; mul_dst = spr_p;
      end
      OP_SQR: begin
        mul_a = sq_p; mul_b = sq_p; mul_dst = spr_p;
      end
      OP_EXIT: begin
        mul_a = acc_p; mul_b = acc_p; mul_b_one = 1'b1; mul_dst = spr_p;
      end
      default: ;  // OP_TOMONT and OP_SINGLE use the defaults
    endcase
  end

  assign mul_start = (st_q == ST_ISSUE);
  assign mul_len   = len_q;
  assign res_slot  = res_q;
endmodule

// File: rtl/modexp_ctl_sva.sv
module modexp_ctl_sva #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mul_start,
  input logic             mul_done,
  input logic [2:0]       mul_a,
  input logic [2:0]       mul_b,
  input logic             mul_b_one,
  input logic [2:0]       mul_dst,
  input logic [LEN_W-1:0] mul_len,
  input logic             busy,
  input logic             done,
  input logic             host_rd_req,
  input logic [2:0]       host_rd_slot,
  input logic             host_rd_grant
);
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         outstanding <= 1'b0;
    else if (mul_start) outstanding <= 1'b1;
    else if (mul_done)  outstanding <= 1'b0;
  end

  a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start |=> !mul_start);
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start |-> busy);
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !mul_start);
  a_r5_dst_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start |-> (mul_dst >= 3'd2 && mul_dst != mul_a && (mul_b_one || mul_dst != mul_b)));
  a_r7_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy ##1 busy) |-> $stable(mul_len));
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $fell(busy)));
  a_r10_exp_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_rd_req && host_rd_slot == 3'd1) |-> !host_rd_grant);
endmodule

bind rl_modexp_seq modexp_ctl_sva #(.LEN_W(LEN_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .mul_start(mul_start), .mul_done(mul_done),
  .mul_a(mul_a), .mul_b(mul_b), .mul_b_one(mul_b_one), .mul_dst(mul_dst),
  .mul_len(mul_len), .busy(busy), .done(done), .host_rd_req(host_rd_req),
  .host_rd_slot(host_rd_slot), .host_rd_grant(host_rd_grant)
);

// File: tb/sim_rl_modexp_seq.sv
module sim_rl_modexp_seq;
  localparam int LEN_W = 12;
  localparam int AW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode_mul = 1'b0;
  logic [LEN_W-1:0] op_len = '0, exp_bits = '0;
  logic [AW-1:0] exp_addr;
  logic [31:0] exp_rdata = '0;
  logic mul_start, mul_b_one, mul_done = 1'b0;
  logic [2:0] mul_a, mul_b, mul_dst, res_slot;
  logic [LEN_W-1:0] mul_len;
  logic busy, done, host_rd_grant;
  logic host_rd_req = 1'b0;
  logic [2:0] host_rd_slot = '0;

  rl_modexp_seq u0 (.*);

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  logic [31:0] emem [64];
  longint slotv [5];
  longint modn, expect_res;
  logic [LEN_W-1:0] exp_len_q;
  int    exp_res_slot;
  bit    bench_busy = 1'b0;
  int    cycles = 0;

  typedef struct { int a; int b; int dst; bit one; } cmd_t;
  cmd_t cq[$];

  always @(negedge clk) exp_rdata <= emem[exp_addr];  // R6 falling-edge read

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic longint mont(input longint a, input longint b);
    longint t = 0;
    for (int i = 0; i < 32; i++) begin
      if (a[i]) t += b;
      if (t[0]) t += modn;
      t = t >>> 1;
    end
    if (t >= modn) t -= modn;
    return t;
  endfunction

  function automatic bit ebit(input int i);
    return emem[i / 32][i % 32];
  endfunction

  // reference: expected command list and result
  task automatic plan_job(input bit single, input int nb, input longint m);
    int acc, sq, spr, tmp;
    longint ra, rs;
    cq.delete();
    cq.push_back('{2, 4, 3, 1'b0});
    if (single) begin
      exp_res_slot = 3;
      expect_res = (m * ((64'd1 << 32) % modn)) % modn;
      return;
    end
    cq.push_back('{4, 4, 2, 1'b1});
    acc = 2; sq = 3; spr = 4;
    ra = 1; rs = m % modn;
    for (int i = 0; i < nb; i++) begin
      if (ebit(i)) begin
        cq.push_back('{acc, sq, spr, 1'b0});
        tmp = acc; acc = spr; spr = tmp;
        ra = (ra * rs) % modn;
      end
      if (i < nb - 1) begin
        cq.push_back('{sq, sq, spr, 1'b0});
        tmp = sq; sq = spr; spr = tmp;
      end
      rs = (rs * rs) % modn;
    end
    cq.push_back('{acc, acc, spr, 1'b1});
    exp_res_slot = spr;
    expect_res = ra;
  endtask

  // multiplier model and command checker
  initial begin
    forever begin
      @(negedge clk);
      if (mul_start) begin
        cmd_t c;
        longint av, bv;
        chk(cq.size() != 0, "R3", "unexpected command", cq.size(), 1);
        if (cq.size() != 0) begin
          c = cq.pop_front();
          chk(mul_a == c.a, "R3", "source A", mul_a, c.a);
          chk(mul_b_one == c.one, "R2", "constant-one flag", mul_b_one, c.one);
          if (!c.one) chk(mul_b == c.b, "R3", "source B", mul_b, c.b);
          chk(mul_dst == c.dst, "R5", "destination", mul_dst, c.dst);
        end
        chk(mul_len == exp_len_q, "R7", "length", mul_len, exp_len_q);
        av = slotv[mul_a];
        bv = mul_b_one ? 64'd1 : slotv[mul_b];
        repeat (3) @(posedge clk);
        #1 mul_done = 1'b1;
        slotv[mul_dst] = mont(av, bv);
        @(posedge clk);
        #1 mul_done = 1'b0;
      end
    end
  end

  // per-cycle checks of guard and completion
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done) begin
          bench_busy = 1'b0;
          chk(cq.size() == 0, "R4", "commands left at done", cq.size(), 0);
          chk(res_slot == exp_res_slot, "R4", "result slot", res_slot, exp_res_slot);
          chk(slotv[res_slot] == expect_res, "R4", "result value", slotv[res_slot], expect_res);
        end
        chk(host_rd_grant == (host_rd_req && !(bench_busy && host_rd_slot == 3'd1)),
            "R10", "host grant", host_rd_grant, host_rd_req);
      end
    end
  end

  initial begin
    int k = 0;
    forever begin
      @(posedge clk);
      #1;
      k++;
      host_rd_req  = k[0] | k[2];
      host_rd_slot = 3'(k[4:2] % 5);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nerr++; nchk++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
      end
    end
  end

  task automatic run_job(input bit single, input int nb, input longint m,
                         input longint n, input int len);
    modn = n;
    slotv[0] = n; slotv[1] = 0; slotv[2] = m % n; slotv[3] = 0;
    slotv[4] = (((64'd1 << 32) % n) * ((64'd1 << 32) % n)) % n;
    plan_job(single, nb, m % n);
    exp_len_q = LEN_W'(len);
    @(posedge clk); #1;
    mode_mul = single; op_len = LEN_W'(len); exp_bits = LEN_W'(nb); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; bench_busy = 1'b1;
    op_len = LEN_W'(len + 7);       // R7: change after start must not matter
    mode_mul = ~single;
    wait (bench_busy == 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) emem[i] = '0;
    repeat (2) @(negedge clk);
    chk(busy == 0, "R1", "busy in reset", busy, 0);
    chk(done == 0, "R1", "done in reset", done, 0);
    chk(mul_start == 0, "R1", "start in reset", mul_start, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && mul_start == 0, "R1", "idle after reset", busy, 0);

    // R3: mixed bit pattern 1011
    emem[0] = 32'hB;
    run_job(1'b0, 4, 12345, 1000003, 1024);
    // R3: one bit, set; no square after last bit
    emem[0] = 32'h1;
    run_job(1'b0, 1, 777, 999983, 2048);
    // R4: all-zero exponent gives 1
    emem[0] = 32'h0;
    run_job(1'b0, 3, 4242, 1000003, 512);
    // R9: single product mode
    run_job(1'b1, 5, 31337, 999983, 1536);
    // R6 and R11: 70-bit exponent across words, start pulsed mid-job
    emem[0] = 32'h8000_0001; emem[1] = 32'h1234_5679; emem[2] = 32'h25;
    fork
      run_job(1'b0, 70, 98765, 2147483629, 2048);
      begin
        repeat (40) @(posedge clk);
        #1 start = 1'b1;            // R11: must be ignored
        @(posedge clk); #1 start = 1'b0;
      end
    join
    repeat (5) @(negedge clk);
    chk(busy == 0 && cq.size() == 0, "R11", "idle after ignored start", busy, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule